// File: doc/BRIEF.md
# Serial Register Write Port with Burst Addressing

This block is the receiving end of a three-wire serial link (clock, data, active-low select) that loads a register bank. While the select line is low, the port samples one data bit on every rising edge of the serial clock. The first eight bits give a register address and each following group of six bits gives a data word. Both are sent least significant bit first. For every complete data word, the port produces a single-cycle write strobe together with the address and the data.

A host may keep the select line low after the first word to stream more words. Each extra word lands at the next address, and the address wraps around at the top of the 8-bit space. A word that is still incomplete when select rises is dropped. This covers the two padding bits that a 16-bit host appends to a 14-bit transfer. The rising edge of select closes the transfer and produces a one-cycle commit pulse, which the register bank uses to update registers that take effect at the end of a frame.

All three serial inputs are asynchronous to the system clock. They are synchronized first, and serial clock edges are detected in the system clock domain. For this reason the serial clock must stay high for at least two system clock cycles and low for at least two system clock cycles.

Top module: `ser_reg_write_port`

## Requirements
- R1: A data bit is taken from `sdata_i` only on a rising edge of `sck_i` while `sl_n_i` is low; serial clock edges while `sl_n_i` is high produce no write strobe.
- R2: The first 8 bits of a transfer form the register address, the first bit received being address bit 0 and the eighth being bit 7.
- R3: The 6 bits following the address form a data word, the first received being data bit 0; once the sixth bit arrives, `wr_en_o` is high for exactly one clock cycle with `wr_addr_o` and `wr_data_o` holding that address and word.
- R4: While `sl_n_i` stays low, every further 6 bits form another data word, written to the address of the previous word plus one.
- R5: Within a burst the address wraps from 0xFF to 0x00.
- R6: A data word with fewer than 6 bits received when `sl_n_i` rises (including 2 padding bits after a 14-bit transfer) causes no write strobe.
- R7: Each rising edge of `sl_n_i` produces a `commit_o` pulse exactly one clock cycle wide, and no other event produces one.
- R8: After `sl_n_i` rises, the next transfer starts again with an 8-bit address, even if the previous transfer was aborted in the middle of its address.
- R9: While `rst` is high and in the first cycle after it falls, `wr_en_o` and `commit_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sck_i | input | 1 | Serial clock, asynchronous |
| sdata_i | input | 1 | Serial data, asynchronous |
| sl_n_i | input | 1 | Transfer select, active low, asynchronous |
| wr_en_o | output | 1 | One-cycle write strobe to the register bank |
| wr_addr_o | output | 8 | Register address of the current write |
| wr_data_o | output | 6 | Data word of the current write |
| commit_o | output | 1 | One-cycle pulse at the end of each transfer |

## Verification
The assertions check four properties on every cycle. Both strobes last exactly one cycle. No strobe appears right after reset. Successive writes inside one transfer step the address by exactly one, wrapping at the top of the address space. The bench scenarios show the rest, because those properties depend on the serial bit order and on how bits group into words. These include bit ordering, grouping of bits into address and words, dropping of partial words and padding bits, ignoring of clock edges while the port is deselected, and recovery after an aborted address phase.

// File: rtl/ser_wr_pkg.sv
package ser_wr_pkg;

    localparam int ADDR_W = 8;
    localparam int DATA_W = 6;

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    localparam int CNT_W = $clog2(max_of(ADDR_W, DATA_W));

    typedef enum logic {
        PH_ADDR = 1'b0,
        PH_DATA = 1'b1
    } phase_t;

    typedef struct packed {
        logic              vld;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } wr_req_t;

endpackage

// File: rtl/ser_wr_sync.sv
module ser_wr_sync #(
    parameter int                WIDTH   = 3,
    parameter int                STAGES  = 2,
    parameter logic [WIDTH-1:0]  RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) begin
                stage_q[s] <= RST_VAL;
            end else if (s == 0) begin
                stage_q[s] <= d_i;
            end else begin
                stage_q[s] <= stage_q[(s > 0) ? s - 1 : 0];
            end
        end
    end

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/ser_wr_edge.sv
module ser_wr_edge #(
    parameter int               WIDTH   = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] sig_i,
    output logic [WIDTH-1:0] rise_o
);
    logic [WIDTH-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= RST_VAL;
        else     prev_q <= sig_i;
    end

    assign rise_o = sig_i & ~prev_q;
endmodule

// File: rtl/ser_wr_deframe.sv
module ser_wr_deframe
    import ser_wr_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    bit_vld_i,
    input  logic    bit_val_i,
    input  logic    frame_end_i,
    output wr_req_t req_o
);
    phase_t            phase_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [ADDR_W-1:0] addr_sh_q;
    logic [DATA_W-1:0] data_sh_q;
    logic [ADDR_W-1:0] cur_addr_q;

    logic [ADDR_W-1:0] addr_nxt;
    logic [DATA_W-1:0] data_nxt;
    logic              addr_last;
    logic              data_last;

    always_comb begin
        addr_nxt  = {bit_val_i, addr_sh_q[ADDR_W-1:1]};
        data_nxt  = {bit_val_i, data_sh_q[DATA_W-1:1]};
        addr_last = (cnt_q == CNT_W'(ADDR_W - 1));
        data_last = (cnt_q == CNT_W'(DATA_W - 1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q    <= PH_ADDR;
            cnt_q      <= '0;
            addr_sh_q  <= '0;
            data_sh_q  <= '0;
            cur_addr_q <= '0;
            req_o      <= '0;
        end else begin
            req_o.vld <= 1'b0;
            if (frame_end_i) begin
                phase_q <= PH_ADDR;
                cnt_q   <= '0;
            end else if (bit_vld_i) begin
                unique case (phase_q)
                    PH_ADDR: begin
                        addr_sh_q <= addr_nxt;
                        if (addr_last) begin
                            cur_addr_q <= addr_nxt;
                            phase_q    <= PH_DATA;
                            cnt_q      <= '0;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    PH_DATA: begin
                        data_sh_q <= data_nxt;
                        if (data_last) begin
                            req_o      <= '{vld: 1'b1, addr: cur_addr_q, data: data_nxt};
                            cur_addr_q <= cur_addr_q + 1'b1;
                            cnt_q      <= '0;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    default: phase_q <= PH_ADDR;
                endcase
            end
        end
    end
endmodule

// File: rtl/ser_reg_write_port.sv
module ser_reg_write_port
    import ser_wr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sck_i,
    input  logic              sdata_i,
    input  logic              sl_n_i,
    output logic              wr_en_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [DATA_W-1:0] wr_data_o,
    output logic              commit_o
);
    // bit order of synchronized vector: {select, data, clock}
    localparam logic [2:0] SYNC_RST = 3'b100;
    localparam logic [1:0] EDGE_RST = 2'b10;

    logic [2:0] sync_q;
    logic [1:0] rise;
    logic       commit_q;
    wr_req_t    req;

    ser_wr_sync #(
        .WIDTH   (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (SYNC_RST)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i ({sl_n_i, sdata_i, sck_i}),
        .q_o (sync_q)
    );

    ser_wr_edge #(
        .WIDTH   (2),
        .RST_VAL (EDGE_RST)
    ) u_edge (
        .clk    (clk),
        .rst    (rst),
        .sig_i  ({sync_q[2], sync_q[0]}),
        .rise_o (rise)
    );

    ser_wr_deframe u_deframe (
        .clk         (clk),
        .rst         (rst),
        .bit_vld_i   (rise[0] & ~sync_q[2]),
        .bit_val_i   (sync_q[1]),
        .frame_end_i (rise[1]),
        .req_o       (req)
    );

    always_ff @(posedge clk) begin
        if (rst) commit_q <= 1'b0;
        else     commit_q <= rise[1];
    end

    assign wr_en_o   = req.vld;
    assign wr_addr_o = req.addr;
    assign wr_data_o = req.data;
    assign commit_o  = commit_q;
endmodule

// File: rtl/ser_reg_write_port_chk.sv
module ser_reg_write_port_chk
    import ser_wr_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              wr_en_o,
    input logic [ADDR_W-1:0] wr_addr_o,
    input logic              commit_o
);
    logic              have_prev_q;
    logic [ADDR_W-1:0] prev_addr_q;

    always_ff @(posedge clk) begin
        if (rst || commit_o) begin
            have_prev_q <= 1'b0;
            prev_addr_q <= '0;
        end else if (wr_en_o) begin
            have_prev_q <= 1'b1;
            prev_addr_q <= wr_addr_o;
        end
    end

    AST_WR_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        wr_en_o |=> !wr_en_o); // R3

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
        (wr_en_o && have_prev_q) |-> (wr_addr_o == ADDR_W'(prev_addr_q + 1'b1))); // R4 R5

    AST_COMMIT_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        commit_o |=> !commit_o); // R7

    AST_RST_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!wr_en_o && !commit_o)); // R9
endmodule

bind ser_reg_write_port ser_reg_write_port_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en_o   (wr_en_o),
    .wr_addr_o (wr_addr_o),
    .commit_o  (commit_o)
);

// File: tb/ser_reg_write_port_bench.sv
module ser_reg_write_port_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sck = 1'b0;
    logic       sdata = 1'b0;
    logic       sl_n = 1'b1;
    logic       wr_en;
    logic [7:0] wr_addr;
    logic [5:0] wr_data;
    logic       commit;

    always #10 clk = ~clk;

    ser_reg_write_port u_ser_reg_write_port (
        .clk       (clk),
        .rst       (rst),
        .sck_i     (sck),
        .sdata_i   (sdata),
        .sl_n_i    (sl_n),
        .wr_en_o   (wr_en),
        .wr_addr_o (wr_addr),
        .wr_data_o (wr_data),
        .commit_o  (commit)
    );

    // Vector fields: [31:24] start address, [23:18] word0, [17:12] word1,
    // [11:6] word2, [5:4] number of full words, [3:2] trailing extra bits
    localparam int NVEC = 5;
    localparam logic [31:0] VEC [NVEC] = '{
        {8'h12, 6'h2A, 6'h00, 6'h00, 2'd1, 2'd0, 2'd0},
        {8'h05, 6'h3F, 6'h01, 6'h15, 2'd3, 2'd0, 2'd0},
        {8'h80, 6'h00, 6'h00, 6'h00, 2'd1, 2'd2, 2'd0},
        {8'hFE, 6'h11, 6'h22, 6'h33, 2'd3, 2'd0, 2'd0},
        {8'h3C, 6'h2D, 6'h12, 6'h00, 2'd2, 2'd3, 2'd0}
    };

    int n_cmp = 0;
    int n_bad = 0;
    int n_wr = 0;
    int n_commit = 0;
    logic clr_req = 1'b0;
    logic [7:0] log_a [16];
    logic [5:0] log_d [16];

    always @(negedge clk) begin
        if (clr_req) begin
            n_wr     <= 0;
            n_commit <= 0;
        end else if (!rst) begin
            if (wr_en) begin
                if (n_wr < 16) begin
                    log_a[n_wr] <= wr_addr;
                    log_d[n_wr] <= wr_data;
                end
                n_wr <= n_wr + 1;
            end
            if (commit) n_commit <= n_commit + 1;
        end
    end

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic clear_log();
        @(negedge clk);
        clr_req = 1'b1;
        @(negedge clk);
        clr_req = 1'b0;
    endtask

    task automatic send_bits(input logic [7:0] val, input int nb);
        for (int i = 0; i < nb; i++) begin
            sdata = val[i];
            sck   = 1'b0;
            repeat (4) @(negedge clk);
            sck = 1'b1;
            repeat (4) @(negedge clk);
        end
        sck = 1'b0;
    endtask

    task automatic end_frame();
        repeat (4) @(negedge clk);
        sl_n = 1'b1;
        repeat (12) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R9: outputs quiet while in reset
        chk(!wr_en && !commit, "R9 in reset", {wr_en, commit}, 0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!wr_en && !commit, "R9 after reset", {wr_en, commit}, 0);
        clear_log();

        // table walk: R2 R3 R4 R5 R6 R7
        for (int v = 0; v < NVEC; v++) begin
            logic [7:0] a0;
            logic [5:0] w [3];
            int nw;
            int nx;
            a0   = VEC[v][31:24];
            w[0] = VEC[v][23:18];
            w[1] = VEC[v][17:12];
            w[2] = VEC[v][11:6];
            nw   = int'(VEC[v][5:4]);
            nx   = int'(VEC[v][3:2]);
            clear_log();
            sl_n = 1'b0;
            repeat (4) @(negedge clk);
            send_bits(a0, 8);
            for (int k = 0; k < nw; k++) send_bits({2'b00, w[k]}, 6);
            if (nx > 0) send_bits(8'hFF, nx);
            end_frame();
            chk(n_wr == nw, "R6 write count", n_wr, nw);
            chk(n_commit == 1, "R7 commit count", n_commit, 1);
            for (int k = 0; k < nw; k++) begin
                logic [7:0] ea;
                ea = a0 + 8'(k);
                chk(log_a[k] == ea, "R2 R4 R5 address", int'(log_a[k]), int'(ea));
                chk(log_d[k] == w[k], "R3 data word", int'(log_d[k]), int'(w[k]));
            end
        end

        // R1: serial clock toggling while deselected
        clear_log();
        send_bits(8'hA5, 8);
        send_bits(8'h3F, 6);
        repeat (12) @(negedge clk);
        chk(n_wr == 0, "R1 edges while deselected", n_wr, 0);
        chk(n_commit == 0, "R7 no commit without select rise", n_commit, 0);

        // R8: abort during address, then full transfer
        clear_log();
        sl_n = 1'b0;
        repeat (4) @(negedge clk);
        send_bits(8'h1F, 5);
        end_frame();
        chk(n_wr == 0, "R6 R8 aborted address no write", n_wr, 0);
        sl_n = 1'b0;
        repeat (4) @(negedge clk);
        send_bits(8'h9C, 8);
        send_bits(8'h27, 6);
        end_frame();
        chk(n_wr == 1, "R8 write count after abort", n_wr, 1);
        chk(log_a[0] == 8'h9C, "R8 address after abort", int'(log_a[0]), 8'h9C);
        chk(log_d[0] == 6'h27, "R8 data after abort", int'(log_d[0]), 6'h27);
        chk(n_commit == 2, "R7 two commits", n_commit, 2);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule